// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block drives the fetch side of a small controller that uses 9-bit instructions. It holds the program counter and a hardware stack of return addresses whose depth is set by a parameter. On each clock it takes the decoded operation, the instruction word and a condition flag, and it produces the address of the next instruction. Steps, taken or untaken branches, calls and returns each complete in one cycle. There are no delay slots.

The fetch address output is combinational from the registered state and the current inputs. A synchronous program memory registers this address at the clock edge. The instruction therefore reaches the decoder in the same cycle that `pc_o` shows its address. While halted, the block holds address zero. A start pulse begins execution at address zero with an empty stack. A halt operation returns the block to idle.

When a call is made with the stack full, the oldest return address is lost and a sticky overflow flag is raised. When a return is made with the stack empty, execution goes to address zero and a sticky underflow flag is raised. Only reset clears these two flags.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the block is idle: `running_o` is 0, `pc_o` and `fetch_addr_o` are 0, and both sticky flags are 0.
- R2: While idle, `fetch_addr_o` is 0 and `op_i`, `instr_i` and `cond_i` have no effect. A 1 on `start_i` in an idle cycle makes the block run from address 0 in the next cycle and empties the return stack. `start_i` is ignored while running.
- R3: Op code 0 (step), and the unused codes 5, 6 and 7, advance the PC by one, wrapping modulo `PMEM_DEPTH`.
- R4: Op code 1 (branch) loads the target `instr_i[AW-1:0]` (AW = log2 of `PMEM_DEPTH`) when `cond_i` is 1. Otherwise it advances the PC by one.
- R5: Op code 2 (call) pushes PC+1 (wrapped) onto the return stack and loads the target in the same cycle.
- R6: Op code 3 (return) pops the most recent return address into the PC in one cycle. Nested calls up to the stack depth return in last-in, first-out order.
- R7: A call with `RSTACK_DEPTH` entries already stored discards the oldest entry, keeps the newest ones, and sets `ovf_o`, which stays set until reset.
- R8: A return with an empty stack loads address 0 and sets `unf_o`, which stays set until reset.
- R9: Op code 4 (halt) makes the block idle in the next cycle, with `pc_o` at 0.
- R10: `fetch_addr_o` always equals the value that `pc_o` takes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, acted on only when idle |
| op_i | input | 3 | Decoded operation code of the current instruction |
| instr_i | input | 9 | Current instruction word; the low bits carry the target |
| cond_i | input | 1 | Branch condition flag |
| fetch_addr_o | output | log2(PMEM_DEPTH) | Address presented to the synchronous program memory |
| pc_o | output | log2(PMEM_DEPTH) | Address of the instruction now being executed |
| running_o | output | 1 | High while executing |
| ovf_o | output | 1 | Sticky return-stack overflow flag |
| unf_o | output | 1 | Sticky return-stack underflow flag |

## Verification
The properties assume that `op_i`, `instr_i` and `cond_i` belong to the instruction at `pc_o`, as a synchronous memory fed from `fetch_addr_o` would supply them. They also assume that the decode inputs are stable for the whole cycle. The bench keeps to this by acting as that memory: at each falling edge it reads its own program tables at the current PC and drives the decoded fields. The only exception is a short idle phase in which it deliberately drives arbitrary opcodes to show that they are ignored. Programs are chosen so that every run ends in a halt or is cut short by reset, since an underflow that loops back to address zero would otherwise repeat forever.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int INSTR_W = 9;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_BRANCH = 3'd1,
        OP_CALL   = 3'd2,
        OP_RETURN = 3'd3,
        OP_HALT   = 3'd4
    } op_e;
endpackage

// File: rtl/seq_target.sv
module seq_target
    import seq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [2:0]         op_i,
    input  logic               cond_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [AW-1:0]      pc_i,
    output logic [AW-1:0]      pc_inc_o,
    output logic [AW-1:0]      target_o,
    output logic               take_o
);
    always_comb begin
        pc_inc_o = pc_i + AW'(1);
        target_o = instr_i[AW-1:0];
        take_o   = 1'b0;
        if (op_i == OP_CALL) begin
            take_o = 1'b1;
        end else if (op_i == OP_BRANCH) begin
            take_o = cond_i;
        end
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    output logic [AW-1:0] top_addr_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
        logic                     ovf;
        logic                     unf;
    } stk_t;

    stk_t s_d, s_q;
    logic [PW-1:0] wp_inc, wp_dec;

    always_comb begin
        wp_inc = (s_q.wp == LAST) ? '0 : s_q.wp + PW'(1);
        wp_dec = (s_q.wp == '0) ? LAST : s_q.wp - PW'(1);

        s_d = s_q;
        if (clear_i) begin
            s_d.wp  = '0;
            s_d.cnt = '0;
        end else if (push_i) begin
            s_d.slot[s_q.wp] = push_addr_i;
            s_d.wp           = wp_inc;
            if (s_q.cnt == FULL) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else if (pop_i) begin
            if (s_q.cnt == '0) begin
                s_d.unf = 1'b1;
            end else begin
                s_d.wp  = wp_dec;
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end

        top_addr_o = (s_q.cnt == '0) ? '0 : s_q.slot[wp_dec];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ovf_o = s_q.ovf;
    assign unf_o = s_q.unf;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import seq_pkg::*;
#(
    parameter int PMEM_DEPTH   = 64,
    parameter int RSTACK_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [2:0]                    op_i,
    input  logic [INSTR_W-1:0]            instr_i,
    input  logic                          cond_i,
    output logic [$clog2(PMEM_DEPTH)-1:0] fetch_addr_o,
    output logic [$clog2(PMEM_DEPTH)-1:0] pc_o,
    output logic                          running_o,
    output logic                          ovf_o,
    output logic                          unf_o
);
    localparam int AW = $clog2(PMEM_DEPTH);

    typedef struct packed {
        logic          run;
        logic [AW-1:0] pc;
    } core_t;

    core_t c_d, c_q;

    logic          stk_clear, stk_push, stk_pop;
    logic [AW-1:0] stk_top, pc_inc, tgt;
    logic          take;

    seq_target #(.AW(AW)) u_target (
        .op_i     (op_i),
        .cond_i   (cond_i),
        .instr_i  (instr_i),
        .pc_i     (c_q.pc),
        .pc_inc_o (pc_inc),
        .target_o (tgt),
        .take_o   (take)
    );

    ret_stack #(.DEPTH(RSTACK_DEPTH), .AW(AW)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (stk_clear),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_addr_i (pc_inc),
        .top_addr_o  (stk_top),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    always_comb begin
        c_d       = c_q;
        stk_clear = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        if (!c_q.run) begin
            c_d.pc = '0;
            if (start_i) begin
                c_d.run   = 1'b1;
                stk_clear = 1'b1;
            end
        end else begin
            unique case (op_i)
                OP_CALL: begin
                    stk_push = 1'b1;
                    c_d.pc   = tgt;
                end
                OP_RETURN: begin
                    stk_pop = 1'b1;
                    c_d.pc  = stk_top;
                end
                OP_HALT: begin
                    c_d.run = 1'b0;
                    c_d.pc  = '0;
                end
                default: c_d.pc = take ? tgt : pc_inc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fetch_addr_o = c_d.pc;
    assign pc_o         = c_q.pc;
    assign running_o    = c_q.run;
endmodule

// File: rtl/pc_sequencer_sva.sv
module pc_sequencer_sva
    import seq_pkg::*;
#(
    parameter int PMEM_DEPTH = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start_i,
    input logic [2:0]                    op_i,
    input logic [INSTR_W-1:0]            instr_i,
    input logic                          cond_i,
    input logic [$clog2(PMEM_DEPTH)-1:0] fetch_addr_o,
    input logic [$clog2(PMEM_DEPTH)-1:0] pc_o,
    input logic                          running_o,
    input logic                          ovf_o,
    input logic                          unf_o
);
    localparam int AW = $clog2(PMEM_DEPTH);

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && start_i) |=> (running_o && pc_o == '0)); // R2
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && (op_i == 3'd0 || op_i >= 3'd5)) |=> (pc_o == $past(pc_o) + AW'(1))); // R3
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && op_i == 3'd1 && cond_i) |=> (pc_o == $past(instr_i[AW-1:0]))); // R4
    AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && op_i == 3'd1 && !cond_i) |=> (pc_o == $past(pc_o) + AW'(1))); // R4
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && op_i == 3'd2) |=> (running_o && pc_o == $past(instr_i[AW-1:0]))); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R7
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o); // R8
    AST_UNF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_o) |-> (pc_o == '0)); // R8
    AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && op_i == 3'd4) |=> (!running_o && pc_o == '0)); // R9
endmodule

bind pc_sequencer pc_sequencer_sva #(.PMEM_DEPTH(PMEM_DEPTH)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .op_i         (op_i),
    .instr_i      (instr_i),
    .cond_i       (cond_i),
    .fetch_addr_o (fetch_addr_o),
    .pc_o         (pc_o),
    .running_o    (running_o),
    .ovf_o        (ovf_o),
    .unf_o        (unf_o)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
    localparam int PM  = 64;
    localparam int DEP = 4;
    localparam int AW  = $clog2(PM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    op_i = 3'd0;
    logic [8:0]    instr_i = 9'd0;
    logic          cond_i = 1'b0;
    logic [AW-1:0] fetch_addr_o, pc_o;
    logic          running_o, ovf_o, unf_o;

    pc_sequencer #(.PMEM_DEPTH(PM), .RSTACK_DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .instr_i(instr_i), .cond_i(cond_i), .fetch_addr_o(fetch_addr_o),
        .pc_o(pc_o), .running_o(running_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string tag   = "R1";

    logic [2:0] p_op [PM];
    logic [8:0] p_ins[PM];
    logic       p_cnd[PM];

    int m_pc, m_run, m_ovf, m_unf;
    int m_q[$];
    int seen[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PM; i++) begin
            p_op[i] = 3'd0; p_ins[i] = 9'd0; p_cnd[i] = 1'b0;
        end
    endtask

    task automatic put(input int a, input logic [2:0] op, input int tgt, input logic c);
        p_op[a]  = op;
        p_ins[a] = {3'b101, 6'(tgt)};
        p_cnd[a] = c;
    endtask

    task automatic model_reset();
        m_pc = 0; m_run = 0; m_ovf = 0; m_unf = 0;
        m_q.delete();
    endtask

    task automatic model_next();
        int inc, tgt;
        inc = (m_pc + 1) % PM;
        tgt = int'(instr_i) % PM;
        if (m_run == 0) begin
            if (start_i) begin m_run = 1; m_q.delete(); end
            m_pc = 0;
        end else begin
            case (op_i)
                3'd1: m_pc = cond_i ? tgt : inc;
                3'd2: begin
                    if (m_q.size() == DEP) begin void'(m_q.pop_front()); m_ovf = 1; end
                    m_q.push_back(inc);
                    m_pc = tgt;
                end
                3'd3: begin
                    if (m_q.size() == 0) begin m_unf = 1; m_pc = 0; end
                    else m_pc = m_q.pop_back();
                end
                3'd4: begin m_run = 0; m_pc = 0; end
                default: m_pc = inc;
            endcase
        end
    endtask

    task automatic tick(input logic st, input bit from_prog,
                        input logic [2:0] mop, input logic [8:0] mins, input logic mc);
        @(negedge clk);
        chk(int'(pc_o) == m_pc, tag, int'(pc_o), m_pc);
        chk(int'(running_o) == m_run, tag, int'(running_o), m_run);
        chk(int'(ovf_o) == m_ovf, {tag, "/R7"}, int'(ovf_o), m_ovf);
        chk(int'(unf_o) == m_unf, {tag, "/R8"}, int'(unf_o), m_unf);
        if (running_o) seen.push_back(int'(pc_o));
        start_i = st;
        if (from_prog) begin
            op_i = p_op[m_pc]; instr_i = p_ins[m_pc]; cond_i = p_cnd[m_pc];
        end else begin
            op_i = mop; instr_i = mins; cond_i = mc;
        end
        model_next();
        #1;
        chk(int'(fetch_addr_o) == m_pc, "R10", int'(fetch_addr_o), m_pc);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 3'd0, 9'd0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 1'b0; op_i = 3'd0; instr_i = 9'd0; cond_i = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_o == '0 && fetch_addr_o == '0, "R1", int'(pc_o), 0);
        chk(!running_o && !ovf_o && !unf_o, "R1",
            int'({running_o, ovf_o, unf_o}), 0);
    endtask

    task automatic chk_seq(input string req, input int exp[$]);
        chk(seen.size() == exp.size(), req, seen.size(), exp.size());
        for (int i = 0; i < exp.size() && i < seen.size(); i++)
            chk(seen[i] == exp[i], req, seen[i], exp[i]);
        seen.delete();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R2: idle ignores decode inputs
        tag = "R2";
        tick(1'b0, 1'b0, 3'd2, 9'h1AB, 1'b1);
        tick(1'b0, 1'b0, 3'd1, 9'h0FF, 1'b1);
        tick(1'b0, 1'b0, 3'd3, 9'h011, 1'b0);
        chk(pc_o == '0 && !running_o, "R2", int'(pc_o), 0);

        // R5 R6: nested calls to full depth, then LIFO returns; branches R4; halt R9
        clear_prog();
        put(0, 3'd2, 10, 0); put(10, 3'd2, 20, 0); put(20, 3'd2, 30, 0);
        put(30, 3'd2, 40, 0); put(40, 3'd3, 0, 0); put(31, 3'd3, 0, 0);
        put(21, 3'd3, 0, 0); put(11, 3'd3, 0, 0); put(1, 3'd1, 50, 1);
        put(50, 3'd1, 55, 0); put(51, 3'd4, 0, 0);
        tag = "R5";
        seen.delete();
        tick(1'b1, 1'b1, 3'd0, 9'd0, 1'b0);
        run(2);
        tick(1'b1, 1'b1, 3'd0, 9'd0, 1'b0);   // R2: start while running is ignored
        tag = "R6";
        run(8);
        tag = "R9";
        run(2);
        chk(!running_o && pc_o == '0, "R9", int'(running_o), 0);
        chk_seq("R6", '{0, 10, 20, 30, 40, 31, 21, 11, 1, 50, 51});

        // R7 then R8: five nested calls drop the oldest, then the chain underflows
        clear_prog();
        put(0, 3'd2, 10, 0); put(10, 3'd2, 20, 0); put(20, 3'd2, 30, 0);
        put(30, 3'd2, 40, 0); put(40, 3'd2, 50, 0); put(50, 3'd3, 0, 0);
        put(41, 3'd3, 0, 0); put(31, 3'd3, 0, 0); put(21, 3'd3, 0, 0);
        put(11, 3'd3, 0, 0);
        tag = "R7";
        tick(1'b1, 1'b1, 3'd0, 9'd0, 1'b0);
        run(6);
        chk(ovf_o == 1'b1, "R7", int'(ovf_o), 1);
        tag = "R8";
        run(5);
        chk(unf_o == 1'b1 && pc_o == '0, "R8", int'(pc_o), 0);
        run(3);
        chk(ovf_o && unf_o, "R7", int'({ovf_o, unf_o}), 3);
        chk_seq("R7", '{0, 10, 20, 30, 40, 50, 41, 31, 21, 11, 0, 10, 20, 30});
        do_reset();

        // R2: start empties the stack; the left-over entry is not returned to
        clear_prog();
        put(0, 3'd2, 5, 0); put(5, 3'd4, 0, 0);
        tag = "R2";
        tick(1'b1, 1'b1, 3'd0, 9'd0, 1'b0);
        run(3);
        clear_prog();
        put(0, 3'd3, 0, 0);
        tick(1'b1, 1'b1, 3'd0, 9'd0, 1'b0);
        run(2);
        chk(unf_o == 1'b1 && pc_o == '0, "R2", int'(pc_o), 0);
        seen.delete();
        do_reset();

        // R3: unused codes step, PC wraps at the top of memory; R4 fall-through
        clear_prog();
        put(0, 3'd1, 63, 0); put(1, 3'd1, 62, 1); put(62, 3'd5, 0, 0);
        put(63, 3'd7, 0, 0);
        tag = "R3";
        seen.delete();
        tick(1'b1, 1'b1, 3'd0, 9'd0, 1'b0);
        run(7);
        chk_seq("R3", '{0, 1, 62, 63, 0, 1, 62});
        do_reset();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule